// File: doc/BRIEF.md
# Cross-Domain Global Control Register

This block holds a small set of control bits that software writes over a simple register bus in a fast bus clock, but that take effect in two slow, independent bit-clock domains: one for the transmit half and one for the receive half. Each half is carried into its own bit-clock domain through a toggle handshake. The value that the slow domain has actually taken is reported back to the bus side.

The register can be reached at three addresses. The combined address writes both halves. When read, it shows only the values each bit-clock domain has acknowledged, so software can poll it to learn when a reset or enable change has really landed. The receive alias and the transmit alias each write one half only. Reading either alias returns the most recently written value of the whole register at once, with no wait on the slow clocks. If a bit clock is stopped, the combined view of its half simply does not change until that clock runs again. Software that polls it should therefore use a time-out.

Top module: `gcr_top`

## Requirements
- R1: After reset, every read address returns zero and both control outputs `tx_ctrl` and `rx_ctrl` are zero.
- R2: Address 0 is the combined view, address 1 the receive alias, address 2 the transmit alias. The receive half occupies data bits [RX_BITS-1:0] and the transmit half the bits directly above it, at all three addresses.
- R3: A combined write updates both halves. A write to an alias updates only its own half; the data bits of the other half are ignored.
- R4: Reading address 1 or 2 returns the last written value of the full register in the first bus cycle after the write edge.
- R5: After a write, the combined read still returns the old value of the written half until that half's bit clock has taken it. `tx_ctrl`/`rx_ctrl` update on the third rising edge of their own bit clock after the write, and the combined read follows on the third bus edge after that.
- R6: While a half's bit clock is stopped, writes to that half never appear at its control output or in the combined read. Once the clock restarts, they do.
- R7: A write to one half leaves the other half's bits and its outstanding handshake untouched.
- R8: A write arriving while the same half's handshake is outstanding replaces the pending value. Only the latest value reaches the control output, and an overwritten value never appears there.
- R9: Address 3 reads as zero, and writes to it change nothing.
- R10: The data offered to a slow domain stays stable while its handshake is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_addr | input | 2 | Register address (0 combined, 1 receive alias, 2 transmit alias) |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | RX_BITS+TX_BITS | Write data |
| bus_rdata | output | RX_BITS+TX_BITS | Read data for `bus_addr`, combinational |
| tx_clk | input | 1 | Transmit bit clock |
| tx_rst_n | input | 1 | Synchronous active-low reset, transmit domain |
| tx_ctrl | output | TX_BITS | Transmit control bits in the transmit domain |
| rx_clk | input | 1 | Receive bit clock |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| rx_ctrl | output | RX_BITS | Receive control bits in the receive domain |

## Verification
The alias readback is due one bus cycle after the write edge and is sampled at the next falling bus edge. The combined readback is sampled in that same cycle, where it must still show the previous value, because no slow edge can have completed the handshake yet. A control output is due three edges of its own bit clock after the write, and the combined readback three bus edges after that. The bench therefore waits a window longer than four periods of the slowest bit clock plus several bus cycles before it compares settled values, and twice that when a pending value has been replaced. For the stopped-clock case it holds the receive clock still across a full window, checks that nothing changed, and then lets the clock run for another window.

// File: rtl/gcr_pkg.sv
// Shared address map for the cross-domain global control register.
package gcr_pkg;
    typedef enum logic [1:0] {
        GCR_ADDR_BOTH = 2'd0,
        GCR_ADDR_RX   = 2'd1,
        GCR_ADDR_TX   = 2'd2,
        GCR_ADDR_NONE = 2'd3
    } gcr_addr_e;
endpackage

// File: rtl/gcr_sync2.sv
// gcr_sync2: two-flop synchronizer for single-bit level or toggle signals.
// Assumes: each bit of d is independent (used only with toggles here).
module gcr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gcr_bus_side.sv
// gcr_bus_side: bus-domain end of one half's handshake.
// Holds the requested value, launches it with a toggle, and keeps at most
// one transfer outstanding. A write during a transfer marks a pending update
// that is relaunched with the latest value once the acknowledge returns.
// The acknowledged shadow is updated from the launched data on acknowledge.
// Assumes: ack_tgl_async is a toggle from the slow domain.
module gcr_bus_side #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ack_tgl_async,
    output logic [W-1:0] req_val,
    output logic [W-1:0] launch_data,
    output logic         req_tgl,
    output logic [W-1:0] shadow
);
    logic         ack_q;
    logic         ack_seen;
    logic         busy;
    logic         dirty;
    logic         ack_edge;
    logic [W-1:0] next_val;

    gcr_sync2 #(.W(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl_async),
        .q     (ack_q)
    );

    assign ack_edge = (ack_q != ack_seen);
    assign next_val = wr_en ? wr_data : req_val;

    // Latest written value, returned by the alias reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     req_val <= '0;
        else if (wr_en) req_val <= wr_data;
    end

    // Record acknowledges and move launched data into the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_seen <= 1'b0;
            shadow   <= '0;
        end else if (ack_edge) begin
            ack_seen <= ack_q;
            shadow   <= launch_data;
        end
    end

    // Launch, relaunch or defer a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_data <= '0;
            req_tgl     <= 1'b0;
            busy        <= 1'b0;
            dirty       <= 1'b0;
        end else if (ack_edge) begin
            if (dirty || wr_en) begin
                launch_data <= next_val;
                req_tgl     <= ~req_tgl;
                dirty       <= 1'b0;
            end else begin
                busy <= 1'b0;
            end
        end else if (wr_en) begin
            if (!busy) begin
                launch_data <= wr_data;
                req_tgl     <= ~req_tgl;
                busy        <= 1'b1;
            end else begin
                dirty <= 1'b1;
            end
        end
    end

    // R10: launched data holds while a transfer is outstanding
    a_r10_launch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack_edge) |=> $stable(launch_data));

    // R8: a new toggle is issued only when idle or on an acknowledge
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_tgl) |-> ($past(!busy) || $past(ack_edge)));

    // R5: the combined shadow moves only on an acknowledge
    a_r5_shadow_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_edge |=> $stable(shadow));

    // R8: the transfer ends only when an acknowledge returns
    a_r8_busy_clears_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(ack_edge));
endmodule

// File: rtl/gcr_clk_side.sv
// gcr_clk_side: bit-clock-domain end of one half's handshake.
// On a synchronized toggle edge it takes the launched data, which the bus
// side holds stable, and echoes the toggle back as the acknowledge.
// Assumes: launch_data does not change while a toggle is in flight.
module gcr_clk_side #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_tgl_async,
    input  logic [W-1:0] launch_data,
    output logic [W-1:0] ctrl,
    output logic         ack_tgl
);
    logic req_q;
    logic seen;

    gcr_sync2 #(.W(1)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl_async),
        .q     (req_q)
    );

    // Take the new value once per toggle and record it as acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            ctrl <= '0;
        end else if (req_q != seen) begin
            seen <= req_q;
            ctrl <= launch_data;
        end
    end

    assign ack_tgl = seen;

    // R5: control bits change only together with an acknowledge
    a_r5_ctrl_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> !$stable(seen));
endmodule

// File: rtl/gcr_top.sv
// gcr_top: global control register with a combined view and two half
// aliases. Receive half in the low bits, transmit half above it.
// Assumes: each reset is synchronous to its own clock; bit clocks are much
// slower than the bus clock and may stop.
module gcr_top #(
    parameter int TX_BITS = 4,
    parameter int RX_BITS = 4
) (
    input  logic                       bus_clk,
    input  logic                       bus_rst_n,
    input  logic [1:0]                 bus_addr,
    input  logic                       bus_wr,
    input  logic [RX_BITS+TX_BITS-1:0] bus_wdata,
    output logic [RX_BITS+TX_BITS-1:0] bus_rdata,
    input  logic                       tx_clk,
    input  logic                       tx_rst_n,
    output logic [TX_BITS-1:0]         tx_ctrl,
    input  logic                       rx_clk,
    input  logic                       rx_rst_n,
    output logic [RX_BITS-1:0]         rx_ctrl
);
    import gcr_pkg::*;

    localparam int DATA_W = RX_BITS + TX_BITS;

    logic               wr_rx, wr_tx;
    logic [RX_BITS-1:0] rx_req, rx_launch, rx_shadow;
    logic [TX_BITS-1:0] tx_req, tx_launch, tx_shadow;
    logic               rx_req_tgl, rx_ack_tgl, tx_req_tgl, tx_ack_tgl;
    gcr_addr_e          addr;

    assign addr  = gcr_addr_e'(bus_addr);
    assign wr_rx = bus_wr && (addr == GCR_ADDR_BOTH || addr == GCR_ADDR_RX);
    assign wr_tx = bus_wr && (addr == GCR_ADDR_BOTH || addr == GCR_ADDR_TX);

    gcr_bus_side #(.W(RX_BITS)) u_rx_bus (
        .clk           (bus_clk),
        .rst_n         (bus_rst_n),
        .wr_en         (wr_rx),
        .wr_data       (bus_wdata[RX_BITS-1:0]),
        .ack_tgl_async (rx_ack_tgl),
        .req_val       (rx_req),
        .launch_data   (rx_launch),
        .req_tgl       (rx_req_tgl),
        .shadow        (rx_shadow)
    );

    gcr_clk_side #(.W(RX_BITS)) u_rx_clk (
        .clk           (rx_clk),
        .rst_n         (rx_rst_n),
        .req_tgl_async (rx_req_tgl),
        .launch_data   (rx_launch),
        .ctrl          (rx_ctrl),
        .ack_tgl       (rx_ack_tgl)
    );

    gcr_bus_side #(.W(TX_BITS)) u_tx_bus (
        .clk           (bus_clk),
        .rst_n         (bus_rst_n),
        .wr_en         (wr_tx),
        .wr_data       (bus_wdata[DATA_W-1:RX_BITS]),
        .ack_tgl_async (tx_ack_tgl),
        .req_val       (tx_req),
        .launch_data   (tx_launch),
        .req_tgl       (tx_req_tgl),
        .shadow        (tx_shadow)
    );

    gcr_clk_side #(.W(TX_BITS)) u_tx_clk (
        .clk           (tx_clk),
        .rst_n         (tx_rst_n),
        .req_tgl_async (tx_req_tgl),
        .launch_data   (tx_launch),
        .ctrl          (tx_ctrl),
        .ack_tgl       (tx_ack_tgl)
    );

    // Read selection: acknowledged view, requested view, or zero.
    always_comb begin
        unique case (addr)
            GCR_ADDR_BOTH: bus_rdata = {tx_shadow, rx_shadow};
            GCR_ADDR_RX,
            GCR_ADDR_TX:   bus_rdata = {tx_req, rx_req};
            default:       bus_rdata = '0;
        endcase
    end

    // R7: a receive-only write leaves the transmit request untouched
    a_r7_rx_alias_isolated: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && addr == GCR_ADDR_RX) |=> $stable(tx_req));

    // R9: writes to the unused address change no request
    a_r9_unused_write: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && addr == GCR_ADDR_NONE) |=> ($stable(tx_req) && $stable(rx_req)));
endmodule

// File: tb/tb_gcr_top.sv
// Bench for gcr_top: a vector table walked by one loop, then directed tests.
module tb_gcr_top;
    localparam int TXB = 4;
    localparam int RXB = 4;
    localparam int DW  = TXB + RXB;
    localparam int SETTLE_NS = 1200;

    // {addr[1:0], wdata[7:0], expected combined after settling[7:0]}
    localparam int NV = 6;
    localparam logic [17:0] VEC [0:NV-1] = '{
        18'h0A5A5, 18'h1F3A3, 18'h26C63, 18'h00000, 18'h2FFF0, 18'h119F9
    };

    logic          bus_clk = 1'b0, tx_clk = 1'b0, rx_clk = 1'b0;
    logic          rx_run = 1'b1;
    logic          bus_rst_n = 1'b0, tx_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [TXB-1:0] tx_ctrl;
    logic [RXB-1:0] rx_ctrl;

    int  total = 0, bad = 0;
    bit  finished = 1'b0;
    bit  mid_seen = 1'b0;
    bit  watch_mid = 1'b0;

    always #2.5 bus_clk = ~bus_clk;
    always #40  tx_clk  = ~tx_clk;
    always #65  if (rx_run) rx_clk = ~rx_clk;

    gcr_top #(.TX_BITS(TXB), .RX_BITS(RXB)) dut (
        .bus_clk  (bus_clk),  .bus_rst_n (bus_rst_n),
        .bus_addr (bus_addr), .bus_wr    (bus_wr),
        .bus_wdata(bus_wdata),.bus_rdata (bus_rdata),
        .tx_clk   (tx_clk),   .tx_rst_n  (tx_rst_n), .tx_ctrl (tx_ctrl),
        .rx_clk   (rx_clk),   .rx_rst_n  (rx_rst_n), .rx_ctrl (rx_ctrl)
    );

    // Flags an overwritten transmit value reaching the output (R8).
    always @(tx_ctrl) if (watch_mid && tx_ctrl == 4'h2) mid_seen = 1'b1;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #100_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [DW-1:0] prev;
        #400;
        @(negedge bus_clk);
        bus_rst_n = 1'b1; tx_rst_n = 1'b1; rx_rst_n = 1'b1;
        #300;
        @(negedge bus_clk);

        // R1: reset values at every address and output
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            check(r == '0, "R1 reset read", r, '0);
        end
        check(tx_ctrl == '0 && rx_ctrl == '0, "R1 reset outputs", {tx_ctrl, rx_ctrl}, '0);

        // R2 R3 R4 R5: vector table
        prev = '0;
        for (int i = 0; i < NV; i++) begin
            logic [1:0]    va;
            logic [DW-1:0] vd, ve;
            {va, vd, ve} = VEC[i];
            wr(va, vd);
            rd(2'd1, r);
            check(r == ve, "R4 rx alias immediate", r, ve);
            rd(2'd2, r);
            check(r == ve, "R4 tx alias immediate", r, ve);
            rd(2'd0, r);
            check(r == prev, "R5 combined held before ack", r, prev);
            #SETTLE_NS;
            @(negedge bus_clk);
            rd(2'd0, r);
            check(r == ve, "R3 combined settled", r, ve);
            check({tx_ctrl, rx_ctrl} == ve, "R2 control outputs", {tx_ctrl, rx_ctrl}, ve);
            prev = ve;
        end

        // R8: back-to-back transmit writes, only the last arrives
        watch_mid = 1'b1;
        wr(2'd2, 8'h10);
        wr(2'd2, 8'h20);
        wr(2'd2, 8'h30);
        #(2 * SETTLE_NS);
        @(negedge bus_clk);
        watch_mid = 1'b0;
        check(tx_ctrl == 4'h3, "R8 latest value delivered", {4'h0, tx_ctrl}, 8'h03);
        check(!mid_seen, "R8 overwritten value never shown", {7'h0, mid_seen}, 8'h00);
        rd(2'd0, r);
        check(r == 8'h39, "R8 combined after replace", r, 8'h39);

        // R6 R7: receive clock stopped, transmit half still progresses
        rx_run = 1'b0;
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h70);
        #SETTLE_NS;
        @(negedge bus_clk);
        rd(2'd0, r);
        check(r == 8'h79, "R6 combined rx half frozen", r, 8'h79);
        check(rx_ctrl == 4'h9, "R6 rx output frozen", {4'h0, rx_ctrl}, 8'h09);
        check(tx_ctrl == 4'h7, "R7 tx half unaffected", {4'h0, tx_ctrl}, 8'h07);
        rd(2'd1, r);
        check(r == 8'h75, "R4 alias during stop", r, 8'h75);
        rx_run = 1'b1;
        #SETTLE_NS;
        @(negedge bus_clk);
        rd(2'd0, r);
        check(r == 8'h75, "R6 combined after restart", r, 8'h75);
        check(rx_ctrl == 4'h5, "R7 rx pending kept", {4'h0, rx_ctrl}, 8'h05);

        // R9: unused address
        wr(2'd3, 8'hFF);
        rd(2'd3, r);
        check(r == '0, "R9 unused reads zero", r, '0);
        rd(2'd1, r);
        check(r == 8'h75, "R9 request unchanged", r, 8'h75);
        #SETTLE_NS;
        @(negedge bus_clk);
        rd(2'd0, r);
        check(r == 8'h75, "R9 combined unchanged", r, 8'h75);
        check({tx_ctrl, rx_ctrl} == 8'h75, "R9 outputs unchanged", {tx_ctrl, rx_ctrl}, 8'h75);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule